// File: doc/BRIEF.md
# Bit-stuffing framer and deframer

This block delimits frames on a serial bit stream by the zero-insertion rule. Its transmit half waits for a start request and then sends a delimiter flag. It then sends the payload, putting a 0 on the line after every run of five payload ones. It ends with a second flag and returns to an idle line of ones. The payload source offers one bit per bit slot and sees a ready signal that drops for the one slot in which a stuffed zero goes out.

The receive half watches the line and ignores everything until it finds a flag. Inside a frame it drops each 0 that follows five ones. It recognises the closing flag at the seventh bit after a run of six ones, and it treats a seventh consecutive one as an abort. Payload bits are held back in a short delay line until seven further candidate bits have arrived, so no bit of a flag is ever released as data. The released bits carry a start marker on the first bit, and separate one-slot pulses report the frame end or an abort. All activity advances only on cycles in which the shared bit-slot enable is high.

Top module: `zs_link`

## Requirements
- R1: While reset is high and after it is released, line_out is 1, tx_ready is 0, and rx_valid, rx_sof, rx_eof and rx_abort are 0 until the line delivers a frame.
- R2: When tx_start is sampled high on a bit slot while the transmitter is idle, that slot still sends 1. The next eight slots send the flag 0,1,1,1,1,1,1,0 in that time order. Then come the payload bits, then the same eight-bit flag, then 1 on every later slot. line_out changes only on bit slots.
- R3: In the payload, after every run of five consecutive ones the transmitter sends one 0. This includes a run that the last payload bit completes, which is stuffed before the closing flag. The run count restarts on every 0, including the stuffed one. Flags are never stuffed.
- R4: In a stuffing slot, tx_ready is 0, line_out becomes 0 and no payload bit is taken. Every payload bit offered with tx_ready high on a bit slot is taken exactly once.
- R5: Before a flag has been seen, the receiver produces no rx_valid, rx_sof, rx_eof or rx_abort, whatever the line carries. A 0 that follows seven or more ones is not a flag.
- R6: Inside a frame, a 0 that follows exactly five ones is discarded. Every other payload bit is released on rx_valid and rx_bit in line order, and no flag bit is released.
- R7: rx_sof is high together with the first released bit of each frame and never with a later one. rx_eof pulses for one cycle when the closing flag completes, provided that the frame released at least one bit.
- R8: A seventh consecutive one inside a frame ends the frame without rx_eof, pulses rx_abort if the frame had released a bit, and returns the receiver to flag hunting. rx_valid, rx_eof and rx_abort are never high together, and each is high only in the cycle after a bit slot.
- R9: Two adjacent flags give no rx_sof and no rx_eof. A closing flag also opens the next frame, so frames separated by single flags are received one after the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable shared by both halves |
| tx_start | input | 1 | Request to begin a frame, sampled on a bit slot while idle |
| tx_bit | input | 1 | Offered payload bit |
| tx_last | input | 1 | Marks the offered bit as the final payload bit |
| tx_ready | output | 1 | Offered bit is taken on this bit slot |
| line_out | output | 1 | Transmitted line bit |
| line_in | input | 1 | Received line bit, sampled on bit slots |
| rx_valid | output | 1 | A payload bit is released |
| rx_bit | output | 1 | Value of the released payload bit |
| rx_sof | output | 1 | First released bit of a frame |
| rx_eof | output | 1 | Closing flag seen for a non-empty frame |
| rx_abort | output | 1 | Frame ended by an illegal run of ones |

## Verification
Two functions can fall in the same slot: the transmitter's end-of-payload decision and a pending stuffed zero, when the last payload bit completes a run of five ones. The receiver has a similar case, in which a held data bit is released in the very slot where the sixth one arrives, before it is known whether the run is a flag. Both are provoked by payloads that end in runs of ones, by all-ones payloads and by frames carrying flag-shaped data, under random bit-slot gaps. The transmitted line is judged slot by slot against a stream encoded in the bench. The received payload and its markers are judged against the bits that were sent.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_OPEN,
        TX_BODY,
        TX_CLOSE
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_FRAME
    } rx_state_e;

    typedef enum logic [1:0] {
        BIT_DATA,
        BIT_STUFF,
        BIT_FLAG,
        BIT_ABORT
    } bit_class_e;

    typedef struct packed {
        logic valid;
        logic data;
        logic sof;
        logic eof;
        logic abort;
    } rx_mark_t;

    // Delimiter bit at position idx (time order) for a stuffing run of 'run':
    // a zero, run+1 ones, a zero.
    function automatic logic flag_bit(input int idx, input int run);
        return (idx == 0 || idx == run + 2) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/zs_run_count.sv
module zs_run_count #(
    parameter int MAXV = 5,
    parameter int INIT = 0,
    localparam int W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clear,
    input  logic         bit_in,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP   = W'(MAXV);
    localparam logic [W-1:0] START = W'(INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= START;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            if (!bit_in) begin
                count <= '0;
            end else if (count != TOP) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/zs_hold.sv
module zs_hold #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic flush,
    input  logic din,
    output logic rel_valid,
    output logic rel_bit
);
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [NW-1:0] FULL = NW'(DEPTH);

    logic [DEPTH-1:0] sh;
    logic [NW-1:0]    fill;

    // The oldest bit leaves only when a newer one displaces it.
    assign rel_valid = push && (fill == FULL);
    assign rel_bit   = sh[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            fill <= '0;
        end else if (flush) begin
            fill <= '0;
        end else if (push) begin
            sh <= {sh[DEPTH-2:0], din};
            if (fill != FULL) begin
                fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/zs_tx.sv
module zs_tx
    import zs_pkg::*;
#(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic start,
    input  logic pay_bit,
    input  logic pay_last,
    output logic pay_ready,
    output logic line,
    output logic in_body
);
    localparam int FLAG_LEN = RUN + 3;
    localparam int IW = $clog2(FLAG_LEN);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] RUN_V   = CW'(RUN);
    localparam logic [CW-1:0] NEAR_V  = CW'(RUN - 1);
    localparam logic [IW-1:0] IDX_END = IW'(FLAG_LEN - 1);

    tx_state_e     st;
    logic [IW-1:0] idx;
    logic [CW-1:0] ones;
    logic          tail_stuff;
    logic          stuff_now;
    logic          next_bit;
    logic          body_step;
    logic          cnt_clear;

    assign in_body   = (st == TX_BODY);
    assign stuff_now = in_body && (ones == RUN_V);
    assign pay_ready = in_body && !stuff_now;

    always_comb begin
        unique case (st)
            TX_OPEN, TX_CLOSE: next_bit = flag_bit(int'(idx), RUN);
            TX_BODY:           next_bit = stuff_now ? 1'b0 : pay_bit;
            default:           next_bit = 1'b1;
        endcase
    end

    // The run count sees the bit actually sent, so a stuffed zero restarts it.
    assign body_step = bit_en && in_body;
    assign cnt_clear = bit_en && !in_body;

    zs_run_count #(.MAXV(RUN), .INIT(0)) u_ones (
        .clk    (clk),
        .rst    (rst),
        .step   (body_step),
        .clear  (cnt_clear),
        .bit_in (next_bit),
        .count  (ones)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= TX_IDLE;
            idx        <= '0;
            tail_stuff <= 1'b0;
            line       <= 1'b1;
        end else if (bit_en) begin
            line <= next_bit;
            unique case (st)
                TX_IDLE: begin
                    if (start) begin
                        st  <= TX_OPEN;
                        idx <= '0;
                    end
                end
                TX_OPEN: begin
                    if (idx == IDX_END) begin
                        st  <= TX_BODY;
                        idx <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                TX_BODY: begin
                    if (stuff_now) begin
                        if (tail_stuff) begin
                            st         <= TX_CLOSE;
                            tail_stuff <= 1'b0;
                        end
                    end else if (pay_last) begin
                        // Last bit completing a run: one more slot for its stuffed zero.
                        if (pay_bit && ones == NEAR_V) begin
                            tail_stuff <= 1'b1;
                        end else begin
                            st <= TX_CLOSE;
                        end
                    end
                end
                default: begin
                    if (idx == IDX_END) begin
                        st  <= TX_IDLE;
                        idx <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/zs_rx.sv
module zs_rx
    import zs_pkg::*;
#(
    parameter int RUN = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     line,
    output rx_mark_t mark
);
    localparam int SAT  = RUN + 2;
    localparam int CW   = $clog2(SAT + 1);
    localparam int HOLD = RUN + 2;
    localparam logic [CW-1:0] STUFF_AT = CW'(RUN);
    localparam logic [CW-1:0] FLAG_AT  = CW'(RUN + 1);

    logic [CW-1:0] ones;
    rx_state_e     st;
    bit_class_e    cls;
    logic          started;
    logic          push;
    logic          flush;
    logic          rel_valid;
    logic          rel_bit;

    // Starts saturated so that a flag needs a leading zero.
    zs_run_count #(.MAXV(SAT), .INIT(SAT)) u_ones (
        .clk    (clk),
        .rst    (rst),
        .step   (bit_en),
        .clear  (1'b0),
        .bit_in (line),
        .count  (ones)
    );

    // Decision on the bit after a run of ones.
    always_comb begin
        if (!line) begin
            if (ones == STUFF_AT)     cls = BIT_STUFF;
            else if (ones == FLAG_AT) cls = BIT_FLAG;
            else                      cls = BIT_DATA;
        end else begin
            cls = (ones >= FLAG_AT) ? BIT_ABORT : BIT_DATA;
        end
    end

    assign push  = bit_en && (st == RX_FRAME) && (cls == BIT_DATA);
    assign flush = bit_en && ((st == RX_HUNT) || (cls == BIT_FLAG) || (cls == BIT_ABORT));

    zs_hold #(.DEPTH(HOLD)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .flush     (flush),
        .din       (line),
        .rel_valid (rel_valid),
        .rel_bit   (rel_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_HUNT;
            started <= 1'b0;
            mark    <= '0;
        end else begin
            mark <= '0;
            if (rel_valid) begin
                mark.valid <= 1'b1;
                mark.data  <= rel_bit;
                mark.sof   <= !started;
                started    <= 1'b1;
            end
            if (bit_en) begin
                unique case (st)
                    RX_HUNT: begin
                        if (cls == BIT_FLAG) begin
                            st      <= RX_FRAME;
                            started <= 1'b0;
                        end
                    end
                    default: begin
                        if (cls == BIT_FLAG) begin
                            if (started) mark.eof <= 1'b1;
                            started <= 1'b0;
                        end else if (cls == BIT_ABORT) begin
                            if (started) mark.abort <= 1'b1;
                            started <= 1'b0;
                            st      <= RX_HUNT;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/zs_link.sv
module zs_link
    import zs_pkg::*;
#(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_start,
    input  logic tx_bit,
    input  logic tx_last,
    output logic tx_ready,
    output logic line_out,
    input  logic line_in,
    output logic rx_valid,
    output logic rx_bit,
    output logic rx_sof,
    output logic rx_eof,
    output logic rx_abort
);
    rx_mark_t mark;
    logic     tx_in_body;

    zs_tx #(.RUN(RUN)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .start     (tx_start),
        .pay_bit   (tx_bit),
        .pay_last  (tx_last),
        .pay_ready (tx_ready),
        .line      (line_out),
        .in_body   (tx_in_body)
    );

    zs_rx #(.RUN(RUN)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .line   (line_in),
        .mark   (mark)
    );

    assign rx_valid = mark.valid;
    assign rx_bit   = mark.data;
    assign rx_sof   = mark.sof;
    assign rx_eof   = mark.eof;
    assign rx_abort = mark.abort;
endmodule

// File: rtl/zs_link_chk.sv
module zs_link_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic tx_ready,
    input logic tx_in_body,
    input logic line_out,
    input logic rx_valid,
    input logic rx_sof,
    input logic rx_eof,
    input logic rx_abort
);
    p_stuff_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_en && tx_in_body && !tx_ready) |=> !line_out);

    p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_out));

    p_sof_with_bit_r7: assert property (@(posedge clk) disable iff (rst)
        rx_sof |-> rx_valid);

    p_marks_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_eof, rx_abort}));

    p_marks_on_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_eof || rx_abort) |-> $past(bit_en));
endmodule

bind zs_link zs_link_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .tx_ready   (tx_ready),
    .tx_in_body (tx_in_body),
    .line_out   (line_out),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_eof     (rx_eof),
    .rx_abort   (rx_abort)
);

// File: tb/sim_zs_link.sv
module sim_zs_link;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, tx_start = 1'b0, tx_bit = 1'b0, tx_last = 1'b0;
    logic raw_sel = 1'b0, raw_bit = 1'b1;
    logic tx_ready, line_out, line_in, rx_valid, rx_bit, rx_sof, rx_eof, rx_abort;

    always #4 clk = ~clk;

    assign line_in = raw_sel ? raw_bit : line_out;

    zs_link u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tx_start(tx_start), .tx_bit(tx_bit),
        .tx_last(tx_last), .tx_ready(tx_ready), .line_out(line_out), .line_in(line_in),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_abort(rx_abort)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic pay [0:511];
    int   pay_len;
    logic exp_line [0:1023];
    int   exp_n, body_lo, body_hi;
    logic got_line [0:1023];
    int   line_n;
    logic got_rx [0:1023];
    int   rx_n, sof_n, eof_n, abort_n, sof_bad, takes;
    bit   expect_sof;
    logic en_q = 1'b0, take_q = 1'b0;

    always @(posedge clk) begin
        en_q   <= bit_en;
        take_q <= bit_en && tx_ready;
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (en_q && line_n < 1024) begin
                got_line[line_n] = line_out;
                line_n++;
            end
            if (take_q) takes++;
            if (rx_valid) begin
                if (rx_sof != expect_sof) sof_bad++;
                expect_sof = 1'b0;
                if (rx_n < 1024) got_rx[rx_n] = rx_bit;
                rx_n++;
            end
            if (rx_sof) sof_n++;
            if (rx_eof) begin eof_n++; expect_sof = 1'b1; end
            if (rx_abort) begin abort_n++; expect_sof = 1'b1; end
        end
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected at most 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clr();
        line_n = 0; rx_n = 0; sof_n = 0; eof_n = 0; abort_n = 0;
        sof_bad = 0; takes = 0; expect_sof = 1'b1;
    endtask

    function automatic logic fbit(input int i);
        return (i == 0 || i == 7) ? 1'b0 : 1'b1;
    endfunction

    task automatic push_exp(input logic b);
        exp_line[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_expected();
        int ones = 0;
        exp_n = 0;
        push_exp(1'b1);
        for (int i = 0; i < 8; i++) push_exp(fbit(i));
        body_lo = exp_n;
        for (int i = 0; i < pay_len; i++) begin
            if (ones == 5) begin push_exp(1'b0); ones = 0; end
            push_exp(pay[i]);
            ones = pay[i] ? ones + 1 : 0;
        end
        if (ones == 5) push_exp(1'b0);
        body_hi = exp_n;
        for (int i = 0; i < 8; i++) push_exp(fbit(i));
    endtask

    task automatic send_frame(input int gappy);
        int idx = 0;
        int guard = 0;
        int mis_flag = 0, mis_body = 0, mis_rx = 0;
        @(posedge clk); #1; bit_en = 1'b0; tx_start = 1'b0;
        @(posedge clk); #1;
        clr();
        build_expected();
        tx_start = 1'b1; bit_en = 1'b1; tx_bit = pay[0]; tx_last = (pay_len == 1);
        @(posedge clk); #1;
        tx_start = 1'b0;
        while (eof_n == 0 && guard < 4000) begin
            if (take_q) idx++;
            tx_bit  = (idx < pay_len) ? pay[idx] : 1'b0;
            tx_last = (idx == pay_len - 1);
            bit_en  = (gappy == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
            @(posedge clk); #1;
            guard++;
        end
        for (int i = 0; i < 16; i++) begin
            bit_en = 1'b1;
            @(posedge clk); #1;
        end
        bit_en = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < exp_n; i++) begin
            logic g;
            g = (i < line_n) ? got_line[i] : 1'bx;
            if (g !== exp_line[i]) begin
                if (i >= body_lo && i < body_hi) mis_body++;
                else mis_flag++;
            end
        end
        for (int i = 0; i < pay_len; i++) begin
            if (i >= rx_n || got_rx[i] !== pay[i]) mis_rx++;
        end
        chk(mis_flag == 0, "R2", "flag/idle slot mismatches", mis_flag, 0);
        chk(mis_body == 0, "R3", "stuffed payload slot mismatches", mis_body, 0);
        chk(takes == pay_len, "R4", "payload bits taken", takes, pay_len);
        chk(rx_n == pay_len, "R6", "released bit count", rx_n, pay_len);
        chk(mis_rx == 0, "R6", "released bit mismatches", mis_rx, 0);
        chk(sof_n == 1 && sof_bad == 0, "R7", "start markers", sof_n, 1);
        chk(eof_n == 1, "R7", "end pulses", eof_n, 1);
        chk(abort_n == 0, "R8", "abort pulses on clean frame", abort_n, 0);
    endtask

    task automatic raw1(input logic b);
        bit_en = 1'b1;
        raw_bit = b;
        @(posedge clk); #1;
    endtask

    task automatic raw_vec(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) raw1(v[i]);
    endtask

    task automatic raw_flag();
        raw_vec(64'h7E, 8);
    endtask

    task automatic raw_idle(input int n);
        for (int i = 0; i < n; i++) raw1(1'b1);
    endtask

    function automatic int rx_mismatch(input logic [63:0] v, input int n);
        int m = 0;
        if (rx_n != n) m++;
        for (int i = 0; i < n; i++) begin
            if (i >= rx_n || got_rx[i] !== v[n - 1 - i]) m++;
        end
        return m;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        clr();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(line_out === 1'b1, "R1", "line_out in reset", int'(line_out), 1);
        chk(tx_ready === 1'b0, "R1", "tx_ready in reset", int'(tx_ready), 0);
        chk({rx_valid, rx_sof, rx_eof, rx_abort} === 4'b0, "R1", "rx markers in reset",
            int'({rx_valid, rx_sof, rx_eof, rx_abort}), 0);
        @(posedge clk); #1; rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(line_out === 1'b1 && tx_ready === 1'b0, "R1", "idle after reset",
            int'({line_out, tx_ready}), 2);

        // Directed loopback frames.
        pay_len = 1; pay[0] = 1'b1;
        send_frame(0);
        pay_len = 5;
        for (int i = 0; i < 5; i++) pay[i] = 1'b1;
        send_frame(0);
        pay_len = 23;
        for (int i = 0; i < 23; i++) pay[i] = 1'b1;
        send_frame(1);
        pay_len = 16;
        for (int i = 0; i < 16; i++) pay[i] = fbit(i % 8);
        send_frame(1);
        pay_len = 12;
        for (int i = 0; i < 12; i++) pay[i] = 1'b0;
        send_frame(0);
        pay_len = 10;
        for (int i = 0; i < 10; i++) pay[i] = (i >= 5);
        send_frame(1);

        // Random loopback frames, biased toward ones.
        for (int f = 0; f < 10; f++) begin
            pay_len = $urandom_range(1, 120);
            for (int i = 0; i < pay_len; i++) pay[i] = ($urandom_range(0, 3) != 0);
            send_frame(f % 2);
        end

        // Raw line stimulus.
        raw_sel = 1'b1;
        raw_idle(10);

        // R5: no flag means no output; seven ones then a zero is not a flag.
        clr();
        raw_vec(64'hAAAAAAAAAA, 40);
        raw_vec(64'hFF, 8);
        raw_vec(64'b01011, 5);
        raw_idle(10);
        chk(rx_n == 0 && sof_n == 0, "R5", "bits released without flag", rx_n, 0);
        chk(eof_n == 0 && abort_n == 0, "R5", "pulses without flag", eof_n + abort_n, 0);

        // R8: frame broken by seven ones.
        clr();
        raw_flag();
        raw_vec(64'b101100101011, 12);
        raw_vec(64'h7F, 7);
        raw1(1'b0);
        raw_idle(10);
        chk(abort_n == 1, "R8", "abort pulses", abort_n, 1);
        chk(eof_n == 0, "R8", "end pulses after abort", eof_n, 0);

        // R8 recovery: hunting finds the next frame.
        clr();
        raw1(1'b0);
        raw_flag();
        raw_vec(64'b0110100111, 10);
        raw_flag();
        raw_idle(10);
        chk(rx_mismatch(64'b0110100111, 10) == 0, "R8", "payload after recovery",
            rx_mismatch(64'b0110100111, 10), 0);
        chk(eof_n == 1 && abort_n == 0, "R8", "end after recovery", eof_n, 1);

        // R9: empty frame between adjacent flags.
        clr();
        raw_flag();
        raw_flag();
        raw_idle(10);
        chk(sof_n == 0 && eof_n == 0 && rx_n == 0, "R9", "markers for empty frame",
            sof_n + eof_n + rx_n, 0);
        chk(abort_n == 0, "R9", "abort on empty frame", abort_n, 0);

        // R9 and R6: shared flags, second frame carries a stuffed zero.
        clr();
        raw_flag();
        raw_vec(64'b110111011, 9);
        raw_flag();
        raw_vec(64'b0111110011, 10);
        raw_flag();
        raw_idle(10);
        chk(rx_mismatch(64'b110111011_011111011, 18) == 0, "R6", "destuffed shared-flag payload",
            rx_mismatch(64'b110111011_011111011, 18), 0);
        chk(eof_n == 2 && sof_n == 2 && sof_bad == 0, "R9", "frames behind shared flag", eof_n, 2);

        bit_en = 1'b0;
        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule